// File: doc/BRIEF.md
# Serial Shift-In Capture Port

This block receives a serial bit stream on one input pin and collects it into a 28-bit shift register, clocked entirely from the core clock. The pin passes through a two-flop synchronizer. Each bit is then taken on a sampling enable made by two cascaded fractional dividers. Each divider can be set to a ratio of 1, 1.5, 2, 2.5 and upward in half steps, so the overall sampling ratio is the product of the two settings.

Software reads the shift register as a 32-bit word, zero-extended. A sticky flag rises once 16 bits have arrived, which tells software that a full 16-bit word is ready to collect. Software then pulses a clear input. This drops the flag and restarts the bit count, but it does not erase the captured bits.

Top module: `serin_capture`

## Requirements
- R1: After a synchronous reset, `cap_word` reads 0 and `word_ready` reads 0.
- R2: On every sample, the synchronized pin value enters bit 0, every held bit moves up one position, and the bit at position 27 is discarded.
- R3: A divider stage with setting k (0 to 2**CFG_W-1) has ratio (k+2)/2. Out of every k+2 enables it receives, it emits exactly two single-cycle pulses. A pulse appears in the cycle after the enable that triggered it, and never without such an enable.
- R4: Stage A counts core cycles and stage B counts stage A pulses. A bit is shifted in on each stage B pulse, so the effective ratio is the product of the two stage ratios.
- R5: `word_ready` rises in the cycle after the 16th sample counted since reset or since the last clear. It then stays high until a clear.
- R6: A high `ready_clr` zeros the bit count and lowers `word_ready` at the next edge. It leaves the captured bits unchanged.
- R7: When a clear and a sample fall on the same cycle, the bit is still shifted in but is not counted.
- R8: The bit shifted in at edge E is the value `ser_in` held at edge E-2 (two-flop synchronizer).
- R9: Bits 31 to 28 of `cap_word` always read 0.
- R10: With both settings at 0, the first sample lands on the 3rd edge after reset is released. With the pin and clear idle, `word_ready` is 0 after 17 edges and 1 after 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data pin |
| ratio_a | input | CFG_W | Stage A setting k, ratio (k+2)/2 |
| ratio_b | input | CFG_W | Stage B setting k, ratio (k+2)/2 |
| ready_clr | input | 1 | Clears the count and the ready flag |
| cap_word | output | OUT_W | Shift register contents, zero-extended |
| word_ready | output | 1 | Sticky flag, 16 bits received |

## Verification
The bench builds the block with its defaults: a 28-bit register, a 16-bit count point and 4-bit divider settings. Small settings keep the runs short while still covering whole-number ratios, half-step ratios and mixed cascades. Long runs at a ratio of 1 push well past 28 bits, so the discard of the oldest bit is exercised. Runs with a dense, random clear bring clears that coincide with samples within reach, as well as repeated re-arming of the flag.

// File: rtl/serin_pkg.sv
package serin_pkg;
  // Half-step count of a divider setting: ratio = half_steps / 2
  function automatic int unsigned half_steps(input int unsigned k);
    return k + 2;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_READY = 2'd2
  } cnt_state_e;
endpackage

// File: rtl/serin_sync.sv
module serin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/serin_frac_div.sv
module serin_frac_div #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             en_in,
  output logic             pulse_out
);
  localparam int ACC_W = CFG_W + 2;

  logic [ACC_W-1:0] limit;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] nxt;
  logic             hit;

  always_comb begin
    limit = ACC_W'(cfg) + ACC_W'(2);
    nxt   = acc + ACC_W'(2);
    hit   = (nxt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      pulse_out <= 1'b0;
    end else begin
      pulse_out <= en_in && hit;
      if (en_in) acc <= hit ? (nxt - limit) : nxt;
    end
  end

  // R3
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> !pulse_out);
  // R3
  unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (en_in && cfg == '0 && $stable(cfg)) |=> pulse_out);
endmodule

// File: rtl/serin_shreg.sv
module serin_shreg
  import serin_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int CNT_AT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              bit_in,
  input  logic              clr,
  output logic [DATA_W-1:0] sr,
  output logic              ready
);
  localparam int CNT_W = $clog2(CNT_AT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CNT_AT - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CNT_AT);

  logic [CNT_W-1:0] cnt;
  cnt_state_e       st;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (sample) sr <= {sr[DATA_W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      st  <= ST_IDLE;
    end else if (clr) begin
      cnt <= '0;
      st  <= ST_IDLE;
    end else if (sample) begin
      if (cnt != FULL) cnt <= cnt + 1'b1;
      if (cnt == LAST || st == ST_READY) st <= ST_READY;
      else st <= ST_COUNT;
    end
  end

  assign ready = (st == ST_READY);

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    sample |=> sr[DATA_W-1:1] == $past(sr[DATA_W-2:0]));
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !clr) |=> ready);
  // R6
  clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !ready);
  // R6
  clear_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !sample) |=> $stable(sr));
endmodule

// File: rtl/serin_capture.sv
module serin_capture
  import serin_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int CNT_AT = 16,
  parameter int CFG_W  = 4,
  parameter int OUT_W  = 32,
  parameter int NUM_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic [CFG_W-1:0] ratio_a,
  input  logic [CFG_W-1:0] ratio_b,
  input  logic             ready_clr,
  output logic [OUT_W-1:0] cap_word,
  output logic             word_ready
);
  localparam int PAD_W = OUT_W - DATA_W;

  logic             pin_s;
  logic [NUM_DIV:0] en_chain;
  logic [CFG_W-1:0] cfg_arr [NUM_DIV];
  logic [DATA_W-1:0] sr;

  assign cfg_arr[0] = ratio_a;
  assign cfg_arr[1] = ratio_b;
  assign en_chain[0] = 1'b1;

  serin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_in(ser_in), .d_out(pin_s)
  );

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    serin_frac_div #(.CFG_W(CFG_W)) u_div (
      .clk(clk), .rst(rst), .cfg(cfg_arr[i]),
      .en_in(en_chain[i]), .pulse_out(en_chain[i+1])
    );
  end

  serin_shreg #(.DATA_W(DATA_W), .CNT_AT(CNT_AT)) u_shreg (
    .clk(clk), .rst(rst), .sample(en_chain[NUM_DIV]), .bit_in(pin_s),
    .clr(ready_clr), .sr(sr), .ready(word_ready)
  );

  assign cap_word = {{PAD_W{1'b0}}, sr};

  // R4
  cascade_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_chain[1] |=> !en_chain[2]);
endmodule

// File: tb/sim_serin_capture.sv
`timescale 1ns/1ps
module sim_serin_capture;
  logic clk = 0;
  logic rst = 1;
  logic ser_in = 0;
  logic [3:0] ratio_a = 0, ratio_b = 0;
  logic ready_clr = 0;
  logic [31:0] cap_word;
  logic word_ready;

  int total = 0, bad = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  serin_capture u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ratio_a(ratio_a), .ratio_b(ratio_b),
    .ready_clr(ready_clr), .cap_word(cap_word), .word_ready(word_ready)
  );

  // Reference model built from the requirements
  logic m_s1, m_s2, m_p1, m_p2, m_flag;
  int   m_a1, m_a2, m_cnt;
  logic [27:0] m_sr;
  int nx;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_p1 <= 0; m_p2 <= 0; m_flag <= 0;
      m_a1 <= 0; m_a2 <= 0; m_cnt <= 0; m_sr <= 0;
    end else begin
      m_s1 <= ser_in; m_s2 <= m_s1;
      nx = m_a1 + 2;
      if (nx >= int'(ratio_a) + 2) begin m_a1 <= nx - (int'(ratio_a) + 2); m_p1 <= 1; end
      else begin m_a1 <= nx; m_p1 <= 0; end
      m_p2 <= 0;
      if (m_p1) begin
        nx = m_a2 + 2;
        if (nx >= int'(ratio_b) + 2) begin m_a2 <= nx - (int'(ratio_b) + 2); m_p2 <= 1; end
        else m_a2 <= nx;
      end
      if (m_p2) m_sr <= {m_sr[26:0], m_s2};
      if (ready_clr) begin m_cnt <= 0; m_flag <= 0; end
      else if (m_p2) begin
        if (m_cnt < 16) m_cnt <= m_cnt + 1;
        if (m_cnt == 15) m_flag <= 1;
      end
    end
  end

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic cyc_check();
    @(negedge clk);
    chk(cap_word == {4'b0, m_sr}, {tag, " R2 R8 word"}, cap_word, {4'b0, m_sr});
    chk(word_ready == m_flag, {tag, " R5 flag"}, {31'b0, word_ready}, {31'b0, m_flag});
    chk(cap_word[31:28] == 4'b0, "R9 pad", {28'b0, cap_word[31:28]}, 32'b0);
  endtask

  task automatic do_reset(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    rst = 1; ratio_a = a; ratio_b = b; ready_clr = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic run(input string t, input int n, input int clr_pct);
    tag = t;
    for (int i = 0; i < n; i++) begin
      ser_in = $urandom_range(0, 1);
      ready_clr = ($urandom_range(0, 99) < clr_pct);
      cyc_check();
    end
    ready_clr = 0;
  endtask

  logic [31:0] held;

  initial begin
    void'($urandom(32'd1234));
    do_reset(0, 0);
    // R1: reset state
    chk(cap_word == 0, "R1 word", cap_word, 0);
    chk(word_ready == 0, "R1 flag", {31'b0, word_ready}, 0);

    // R10: directed timing at ratio 1 x 1
    ser_in = 0;
    for (int i = 0; i < 17; i++) @(negedge clk);
    chk(word_ready == 0, "R10 flag after 17", {31'b0, word_ready}, 0);
    @(negedge clk);
    chk(word_ready == 1, "R10 flag after 18", {31'b0, word_ready}, 1);

    // R3 R4: several ratio pairs
    do_reset(0, 0);  run("R2", 200, 0);
    do_reset(1, 0);  run("R3", 300, 0);
    do_reset(0, 1);  run("R3", 300, 0);
    do_reset(1, 1);  run("R4", 400, 0);
    do_reset(2, 3);  run("R4", 800, 2);
    for (int r = 0; r < 4; r++) begin
      do_reset(4'($urandom_range(0, 5)), 4'($urandom_range(0, 5)));
      run("R4", 600, 3);
    end

    // R7: dense clears at ratio 1 hit coinciding samples
    do_reset(0, 0);  run("R7", 500, 20);
    do_reset(1, 0);  run("R7", 500, 15);

    // R6: clear keeps captured bits (no sampling in window)
    do_reset(15, 15);
    tag = "R6";
    ser_in = 1;
    for (int i = 0; i < 600; i++) cyc_check();
    held = cap_word;
    ready_clr = 1; cyc_check(); ready_clr = 0; cyc_check();
    chk(word_ready == 0, "R6 flag cleared", {31'b0, word_ready}, 0);
    chk(cap_word == held || m_sr != held[27:0], "R6 bits kept", cap_word, held);

    // R5: sticky flag across long run, then R8 single-cycle pulse
    do_reset(0, 0); run("R5", 100, 0);
    tag = "R8";
    ser_in = 0;
    @(negedge clk); ser_in = 1; cyc_check(); ser_in = 0;
    for (int i = 0; i < 6; i++) cyc_check();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule